// File: doc/BRIEF.md
# Pipelined Burst SRAM Front-End

A synchronous word-wide memory with registered inputs and a registered read path. Each rising edge captures the address, strobes, chip selects, write controls and write data into an input register. The decode and array access then act on that captured set, and read data lands in an output register one edge later. A cycle is started by either a processor strobe or a controller strobe and is qualified by three chip selects. Once a cycle has started, an advance input steps the low two address bits through a four-beat sequence. The order of that sequence is linear or interleaved, as picked by a static mode pin.

The data bus is split into an input, an output and an output-enable, which a pad ring combines into one shared bus. The pins work on fixed timing and have no back-pressure. No valid/ready pair exists: the host owns the timing, and the block never stalls. Writes can cover the whole word or any set of byte lanes. A sleep input freezes the array and floats the bus.

Top module: `psb_sram`

## Requirements
- R1: Inputs are captured on a rising edge. A read whose start is presented before edge N drives `dq_out` with the addressed word after edge N+1, provided `oe_n` is low.
- R2: A start needs `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe seen while these are not all true is a deselect: the burst ends, the bus floats after the next edge, and later advance cycles have no effect.
- R3: `adsp_n` is ignored while `ce1_n` is high. In that case the cycle is decoded from `adsc_n` and `adv_n` alone.
- R4: A cycle started by `adsp_n` is always a read, whatever the write inputs say. Writes in that burst are made by later advance or hold cycles.
- R5: Byte lane i covers bits 8i+7..8i. With `gw_n`=0 all four lanes are written. With `gw_n`=1 and `bwe_n`=0, lane i is written when `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1 the cycle is a read.
- R6: Each advance cycle (`adv_n`=0 during an active burst) moves to beat n+1. The low two address bits are base+n mod 4 when `lin_mode`=1 and base XOR n when `lin_mode`=0. The upper bits stay fixed, and the sequence wraps after four beats.
- R7: A cycle with both strobes and `adv_n` high keeps the current address. It writes the enabled lanes there, if any. With no write, the output register and the bus state stay unchanged.
- R8: Any write cycle floats the bus after its edge. The bus stays floated until a read made by a strobe or an advance cycle.
- R9: `oe_n` high floats the bus at once and changes no internal state.
- R10: While the captured `zz` is high, no read or write takes place, the burst ends and the bus floats. After sleep ends, the bus stays floated until a new read.
- R11: After reset the bus is floated and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, captured at starts |
| adsp_n | input | 1 | Processor start strobe, active low |
| adsc_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Full-word write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| zz | input | 1 | Sleep request, active high |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| dq_in | input | DW | Write data from the shared bus |
| dq_out | output | DW | Read data toward the shared bus |
| dq_oe | output | 1 | Drive enable for the shared bus |

## Verification
The embedded assertions check properties that hold on every cycle. A read-type decode must raise the output-valid state one edge later. A write, a deselect or a captured sleep must drop it. A processor-strobe start must never produce a write mask. With `ce1_n` high and no controller strobe, no start or deselect may occur. A hold cycle must leave the burst base and beat count unchanged. The bench's scenarios cover what the assertions cannot see. These are the data values that come back after full and partial writes, and the two beat orders including the wrap. They also include the two-edge read latency and the bus staying floated after writes and sleep until the next read. Each of these is compared every clock against a behavioural model of the memory.

// File: rtl/psb_pkg.sv
package psb_pkg;

  typedef struct packed {
    logic adsp_n;
    logic adsc_n;
    logic adv_n;
    logic ce1_n;
    logic ce2;
    logic ce3_n;
    logic gw_n;
    logic bwe_n;
    logic zz;
  } psb_ctl_t;

  localparam psb_ctl_t CTL_IDLE = '{adsp_n: 1'b1, adsc_n: 1'b1, adv_n: 1'b1,
                                    ce1_n: 1'b1, ce2: 1'b0, ce3_n: 1'b1,
                                    gw_n: 1'b1, bwe_n: 1'b1, zz: 1'b0};

  // low two address bits of beat n for a given starting offset
  function automatic logic [1:0] beat_lsb(input logic [1:0] base,
                                          input logic [1:0] n,
                                          input logic       lin);
    return lin ? (base + n) : (base ^ n);
  endfunction

endpackage

// File: rtl/psb_in_reg.sv
module psb_in_reg
  import psb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  psb_ctl_t         ctl_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_n_i,
  input  logic [DW-1:0]    din_i,
  output psb_ctl_t         ctl_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] bw_n_q,
  output logic [DW-1:0]    din_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= CTL_IDLE;
      addr_q <= '0;
      bw_n_q <= '1;
      din_q  <= '0;
    end else begin
      ctl_q  <= ctl_i;
      addr_q <= addr_i;
      bw_n_q <= bw_n_i;
      din_q  <= din_i;
    end
  end

endmodule

// File: rtl/psb_ctrl.sv
module psb_ctrl
  import psb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  psb_ctl_t         ctl,
  input  logic [LANES-1:0] bw_n,
  input  logic             active,
  output logic             load,
  output logic             step,
  output logic             stop,
  output logic             rd,
  output logic [LANES-1:0] wr_mask
);

  logic             sel;
  logic             acc;
  logic             hold;
  logic             rd_only;
  logic [LANES-1:0] lane_mask;

  assign sel = !ctl.ce1_n && ctl.ce2 && !ctl.ce3_n;

  always_comb begin
    if (!ctl.gw_n)       lane_mask = '1;
    else if (!ctl.bwe_n) lane_mask = ~bw_n;
    else                 lane_mask = '0;
  end

  always_comb begin
    load    = 1'b0;
    step    = 1'b0;
    stop    = 1'b0;
    acc     = 1'b0;
    hold    = 1'b0;
    rd_only = 1'b0;
    if (ctl.zz) begin
      stop = 1'b1;
    end else if (!ctl.adsp_n && !ctl.ce1_n) begin
      if (sel) begin
        load    = 1'b1;
        rd_only = 1'b1;
      end else begin
        stop = 1'b1;
      end
    end else if (!ctl.adsc_n) begin
      if (sel) begin
        load = 1'b1;
        acc  = 1'b1;
      end else begin
        stop = 1'b1;
      end
    end else if (!ctl.adv_n) begin
      if (active) begin
        step = 1'b1;
        acc  = 1'b1;
      end
    end else begin
      hold = active;
    end
  end

  assign rd      = rd_only || (acc && (lane_mask == '0));
  assign wr_mask = ((acc || hold) && !rd_only) ? lane_mask : '0;

  // R4: a processor-strobe start never writes
  a_r4_adsp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.zz && !ctl.adsp_n && !ctl.ce1_n) |-> (wr_mask == '0));

  // R3: with ce1_n high only the controller strobe can start or deselect
  a_r3_adsp_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ce1_n && ctl.adsc_n && !ctl.zz) |-> (!load && !stop));

endmodule

// File: rtl/psb_burst.sv
module psb_burst
  import psb_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          stop,
  input  logic          lin,
  input  logic [AW-1:0] ld_addr,
  output logic [AW-1:0] cur_addr,
  output logic          active
);

  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cnt_use;

  assign cnt_use  = step ? cnt + 2'd1 : cnt;
  assign cur_addr = load ? ld_addr
                         : {base[AW-1:2], beat_lsb(base[1:0], cnt_use, lin)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (stop) begin
      active <= 1'b0;
    end else if (load) begin
      base   <= ld_addr;
      cnt    <= '0;
      active <= 1'b1;
    end else if (step) begin
      cnt <= cnt_use;
    end
  end

  // R7: a cycle with no start, advance or stop keeps the burst position
  a_r7_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && !step && !stop) |=> ($stable(cnt) && $stable(base)));

endmodule

// File: rtl/psb_array.sv
module psb_array #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 8,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             flush,
  input  logic [LANES-1:0] wr_mask,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    q,
  output logic             q_en
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (!flush && wr_mask[l]) mem[addr][l*LW +: LW] <= din[l*LW +: LW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      q_en <= 1'b0;
    end else if (flush || (wr_mask != '0)) begin
      q_en <= 1'b0;
    end else if (rd) begin
      q    <= mem[addr];
      q_en <= 1'b1;
    end
  end

  // R1: a read decode puts valid data in the output register one edge later
  a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !flush && (wr_mask == '0)) |=> q_en);

  // R8: a write leaves the output register invalid
  a_r8_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask != '0) |=> !q_en);

  // R2: a deselect or sleep drains the output
  a_r2_flush_floats: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !q_en);

endmodule

// File: rtl/psb_sram.sv
module psb_sram
  import psb_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LANES = 4,
  parameter int LW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  input  logic             zz,
  input  logic             lin_mode,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);

  psb_ctl_t         ctl_raw;
  psb_ctl_t         ctl_r;
  logic [AW-1:0]    addr_r;
  logic [LANES-1:0] bw_n_r;
  logic [DW-1:0]    din_r;
  logic             load, step, stop, rd, active;
  logic [LANES-1:0] wr_mask;
  logic [AW-1:0]    cur_addr;
  logic             q_en;

  assign ctl_raw = '{adsp_n: adsp_n, adsc_n: adsc_n, adv_n: adv_n,
                     ce1_n: ce1_n, ce2: ce2, ce3_n: ce3_n,
                     gw_n: gw_n, bwe_n: bwe_n, zz: zz};

  psb_in_reg #(.AW(AW), .DW(DW), .LANES(LANES)) u_in (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_raw), .addr_i(addr), .bw_n_i(bw_n),
    .din_i(dq_in), .ctl_q(ctl_r), .addr_q(addr_r), .bw_n_q(bw_n_r), .din_q(din_r)
  );

  psb_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_r), .bw_n(bw_n_r), .active(active),
    .load(load), .step(step), .stop(stop), .rd(rd), .wr_mask(wr_mask)
  );

  psb_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .stop(stop),
    .lin(lin_mode), .ld_addr(addr_r), .cur_addr(cur_addr), .active(active)
  );

  psb_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(cur_addr), .rd(rd), .flush(stop),
    .wr_mask(wr_mask), .din(din_r), .q(dq_out), .q_en(q_en)
  );

  assign dq_oe = q_en && !oe_n;

  // R10: a captured sleep request leaves the bus floated after the next edge
  a_r10_sleep_float: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_r.zz |=> !dq_oe);

  // R9: output enable high never drives the bus
  a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

endmodule

// File: tb/psb_sram_bench.sv
`timescale 1ns/1ps
module psb_sram_bench;

  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        adsp_n = 1, adsc_n = 1, adv_n = 1;
  logic        ce1_n = 0, ce2 = 1, ce3_n = 0;
  logic        gw_n = 1, bwe_n = 1;
  logic [3:0]  bw_n = 4'hF;
  logic        oe_n = 1, zz = 0, lin_mode = 1;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic        dq_oe;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R11";
  bit    run_cmp = 0;
  bit    done = 0;

  always #2 clk = ~clk;

  psb_sram #(.DEPTH(DEPTH)) u_psb_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .lin_mode(lin_mode),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] ref_mem [DEPTH];
  bit          m_drive, m_act;
  int          m_base, m_cnt;
  logic [31:0] m_q;
  bit p_sp, p_sc, p_av, p_c1, p_c2, p_c3, p_gw, p_be, p_zz;
  logic [3:0]  p_bw;
  int          p_addr;
  logic [31:0] p_d;

  function automatic int beat_addr(input int b, input int n, input bit lin);
    int lo;
    lo = lin ? ((b + n) & 3) : ((b ^ n) & 3);
    return (b & ~3) | lo;
  endfunction

  task automatic m_access(input int a, input logic [3:0] mk);
    if (mk != 0) begin
      for (int l = 0; l < 4; l++)
        if (mk[l]) ref_mem[a][l*8 +: 8] = p_d[l*8 +: 8];
      m_drive = 0;
    end else begin
      m_q = ref_mem[a];
      m_drive = 1;
    end
  endtask

  always @(posedge clk) begin
    bit sel;
    logic [3:0] mk;
    if (!rst_n) begin
      m_drive = 0; m_act = 0; m_base = 0; m_cnt = 0; m_q = '0;
      p_sp = 1; p_sc = 1; p_av = 1; p_c1 = 1; p_c2 = 0; p_c3 = 1;
      p_gw = 1; p_be = 1; p_zz = 0; p_bw = 4'hF; p_addr = 0; p_d = '0;
    end else begin
      sel = !p_c1 && p_c2 && !p_c3;
      mk  = !p_gw ? 4'hF : (!p_be ? ~p_bw : 4'h0);
      if (p_zz) begin
        m_drive = 0; m_act = 0;
      end else if (!p_sp && !p_c1) begin
        if (sel) begin
          m_base = p_addr; m_cnt = 0; m_act = 1; m_access(p_addr, 4'h0);
        end else begin
          m_act = 0; m_drive = 0;
        end
      end else if (!p_sc) begin
        if (sel) begin
          m_base = p_addr; m_cnt = 0; m_act = 1; m_access(p_addr, mk);
        end else begin
          m_act = 0; m_drive = 0;
        end
      end else if (!p_av) begin
        if (m_act) begin
          m_cnt = (m_cnt + 1) & 3;
          m_access(beat_addr(m_base, m_cnt, lin_mode), mk);
        end
      end else if (m_act && mk != 0) begin
        m_access(beat_addr(m_base, m_cnt, lin_mode), mk);
      end
      p_sp = adsp_n; p_sc = adsc_n; p_av = adv_n; p_c1 = ce1_n; p_c2 = ce2;
      p_c3 = ce3_n; p_gw = gw_n; p_be = bwe_n; p_zz = zz; p_bw = bw_n;
      p_addr = int'(addr); p_d = dq_in;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (run_cmp && !done) begin
      chk({tag, " bus enable"}, {31'b0, dq_oe}, {31'b0, m_drive && !oe_n});
      if (m_drive && !oe_n) chk({tag, " read data"}, dq_out, m_q);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cyc(input logic sp, input logic sc, input logic av, input int a,
                     input logic g, input logic be, input logic [3:0] b,
                     input logic [31:0] d);
    adsp_n = sp; adsc_n = sc; adv_n = av; addr = a[7:0];
    gw_n = g; bwe_n = be; bw_n = b; dq_in = d;
    tick();
  endtask

  task automatic nop();
    cyc(1, 1, 1, 0, 1, 1, 4'hF, 32'h0);
  endtask

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h01030507) ^ 32'hA5C30000;
  endfunction

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R11: reset state
    chk("R11 reset float", {31'b0, dq_oe}, 32'h0);
    oe_n = 0;
    chk("R11 reset float oe low", {31'b0, dq_oe}, 32'h0);
    rst_n = 1;
    run_cmp = 1;

    // R5: fill with full-word writes through the controller strobe
    tag = "R5 fill";
    oe_n = 1;
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 1, i, 0, 1, 4'hF, pat(i));
    nop();

    // R1 and R8: read latency after writes
    tag = "R1 latency";
    oe_n = 0;
    cyc(1, 0, 1, 5, 1, 1, 4'hF, 0);
    chk("R8 float one edge after read start", {31'b0, dq_oe}, 32'h0);
    nop();
    chk("R1 drive after second edge", {31'b0, dq_oe}, 32'h1);
    chk("R1 data after second edge", dq_out, pat(5));

    // R9: oe_n high floats, data kept
    tag = "R9 oe";
    oe_n = 1; #1;
    chk("R9 oe high floats", {31'b0, dq_oe}, 32'h0);
    nop();
    oe_n = 0; #1;
    chk("R9 data kept", dq_out, pat(5));

    // R4: processor strobe with write controls is a read
    tag = "R4 adsp";
    cyc(0, 1, 1, 9, 0, 1, 4'hF, 32'hDEADBEEF);
    nop();
    chk("R4 adsp write ignored", dq_out, pat(9));
    oe_n = 1;
    cyc(1, 1, 0, 0, 0, 1, 4'hF, 32'h11112222); // write on beat 1
    nop();
    oe_n = 0;
    cyc(1, 0, 1, 9, 1, 1, 4'hF, 0);
    cyc(1, 1, 0, 0, 1, 1, 4'hF, 0);
    chk("R4 start word intact", dq_out, pat(9));
    nop();
    chk("R4 advance write landed", dq_out, 32'h11112222);

    // R3: processor strobe masked by ce1_n high, burst continues
    tag = "R3 ce1";
    cyc(1, 0, 1, 16, 1, 1, 4'hF, 0);
    ce1_n = 1;
    cyc(0, 1, 1, 40, 1, 1, 4'hF, 0);
    ce1_n = 0;
    cyc(1, 1, 0, 0, 1, 1, 4'hF, 0);
    nop();
    chk("R3 burst kept after masked strobe", dq_out, pat(17));

    // R2: deselect via controller strobe, advance then has no effect
    tag = "R2 deselect";
    ce2 = 0;
    cyc(1, 0, 1, 30, 1, 1, 4'hF, 0);
    ce2 = 1;
    cyc(1, 1, 0, 0, 1, 1, 4'hF, 0);
    chk("R2 float after deselect", {31'b0, dq_oe}, 32'h0);
    nop();
    chk("R2 advance ignored", {31'b0, dq_oe}, 32'h0);

    // R6: both beat orders with wrap
    for (int md = 0; md < 2; md++) begin
      lin_mode = md[0];
      tag = md ? "R6 linear" : "R6 interleave";
      cyc(1, 0, 1, 66, 1, 1, 4'hF, 0);
      for (int b = 1; b < 6; b++) begin
        cyc(1, 1, 0, 0, 1, 1, 4'hF, 0);
        chk(md ? "R6 linear beat" : "R6 interleave beat", dq_out,
            pat(beat_addr(66, b - 1, md[0])));
      end
      nop();
    end

    // R7: hold cycles keep address, write in place; R8 float after write
    tag = "R7 hold";
    lin_mode = 1;
    cyc(1, 0, 1, 100, 1, 1, 4'hF, 0);
    nop(); nop();
    chk("R7 hold keeps data", dq_out, pat(100));
    oe_n = 1;
    cyc(1, 1, 1, 0, 1, 0, 4'b1010, 32'h77665544);
    oe_n = 0;
    nop();
    chk("R8 float after hold write", {31'b0, dq_oe}, 32'h0);
    nop();
    chk("R8 still float", {31'b0, dq_oe}, 32'h0);
    cyc(1, 1, 0, 0, 1, 1, 4'hF, 0);
    nop();
    chk("R8 advance read drives", {31'b0, dq_oe}, 32'h1);
    cyc(1, 0, 1, 100, 1, 1, 4'hF, 0);
    nop();
    chk("R5 R7 lane merge", dq_out, {pat(100)[31:24], 8'h66, pat(100)[15:8], 8'h44});

    // R10: sleep
    tag = "R10 sleep";
    ce1_n = 1;
    cyc(1, 0, 1, 0, 1, 1, 4'hF, 0);
    ce1_n = 0;
    zz = 1;
    cyc(1, 0, 1, 120, 0, 1, 4'hF, 32'h0BADF00D);
    cyc(1, 0, 1, 121, 0, 1, 4'hF, 32'h0BADF00D);
    zz = 0;
    nop(); nop();
    chk("R10 float after sleep", {31'b0, dq_oe}, 32'h0);
    cyc(1, 0, 1, 120, 1, 1, 4'hF, 0);
    nop();
    chk("R10 no write in sleep", dq_out, pat(120));

    // mixed random traffic against the model
    tag = "R1 R2 R5 R6 random";
    for (int k = 0; k < 4000; k++) begin
      int kind;
      logic g, be;
      logic [3:0] b;
      kind = $urandom_range(0, 9);
      g  = ($urandom_range(0, 3) == 0) ? 1'b0 : 1'b1;
      be = $urandom_range(0, 1);
      b  = $urandom;
      oe_n = ($urandom_range(0, 5) == 0);
      lin_mode = (kind == 0) ? $urandom_range(0, 1) : lin_mode;
      if ($urandom_range(0, 7) == 0) begin
        ce1_n = $urandom; ce2 = $urandom; ce3_n = $urandom;
      end else begin
        ce1_n = 0; ce2 = 1; ce3_n = 0;
      end
      zz = ($urandom_range(0, 60) == 0);
      case (kind)
        0, 1:    cyc(0, $urandom, 1, $urandom_range(0, DEPTH - 1), g, be, b, $urandom);
        2, 3:    cyc(1, 0, 1, $urandom_range(0, DEPTH - 1), g, be, b, $urandom);
        4, 5, 6: cyc(1, 1, 0, $urandom_range(0, DEPTH - 1), g, be, b, $urandom);
        7:       cyc(1, 1, 1, 0, g, be, b, $urandom);
        default: cyc(1, 1, 0, 0, 1, 1, 4'hF, 0);
      endcase
    end
    zz = 0;
    nop(); nop();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule